// File: doc/BRIEF.md
# Record-form XOR execute unit

This block decodes one 32-bit register-register XOR instruction and executes it against an external 64-bit, 32-entry general register file. It presents the two source register indices on combinational read-address outputs and takes the read data back. It drives the bitwise XOR result onto a single write port, together with a write enable and the destination index. A record variant of the instruction also sets the first condition-register field. That field holds a signed comparison of the result against zero, plus a copy of the summary-overflow input. The program counter advances by four for every executed instruction.

A mode input chooses how the result is viewed for the condition update. In full-width mode all 64 bits are compared. In compatibility mode only the low 32 bits are used, sign-extended to 64 bits first. The register write is 64 bits wide in both modes. Any word that is not this instruction raises a flag and changes nothing. The result and the condition nibble are computed combinationally, and the program counter and the condition register commit on the rising clock edge on which `valid` is high.

Top module: `xor_record_unit`

## Requirements
- R1: A word is executed only when bits [31:26] equal 31 and bits [10:1] equal 316. The fields are: first source index in [25:21], destination index in [20:16], second source index in [15:11], and record flag in [0]. With every other field zero, such a word is 0x7C000278. When `valid` is high on an executed word, `gpr_we` is 1, `gpr_waddr` equals the destination field, and `rs_idx` and `rb_idx` equal the two source fields.
- R2: `gpr_wdata` is the full 64-bit bitwise XOR of `rs_data` and `rb_data`.
- R3: When the record flag is 1 in full-width mode (`compat_mode`=0), `cr[31:28]` becomes {LT,GT,EQ,SO} after the edge. Exactly one of LT, GT and EQ is set, from a signed 64-bit comparison of the result with zero.
- R4: On a record update, `cr[28]` takes the value of `xer_so`.
- R5: In compatibility mode (`compat_mode`=1), the comparison uses the low 32 bits of the result sign-extended to 64 bits. `gpr_wdata` still carries all 64 bits.
- R6: When the record flag is 0, `cr` is unchanged across the edge.
- R7: `cr[27:0]` never changes as a result of an instruction.
- R8: `pc` increases by 4 after each edge on which an instruction executes.
- R9: When `valid` is high and the word does not match, `illegal` is 1, `gpr_we` is 0, and `pc` and `cr` are unchanged after the edge.
- R10: When `valid` is low, `gpr_we` and `illegal` are 0, and `pc` and `cr` hold.
- R11: A synchronous reset clears `pc` and `cr` to zero.
- R12: When both sources name the same register, the result is zero. A record-form instruction then sets EQ in both compare modes.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Fetched instruction word |
| xer_so | input | 1 | Summary-overflow bit to copy on a record update |
| compat_mode | input | 1 | 1 selects the 32-bit sign-extended compare view |
| rs_data | input | 64 | Read data for the first source |
| rb_data | input | 64 | Read data for the second source |
| rs_idx | output | 5 | Read address for the first source |
| rb_idx | output | 5 | Read address for the second source |
| gpr_we | output | 1 | Register write enable |
| gpr_waddr | output | 5 | Register write address |
| gpr_wdata | output | 64 | Register write data |
| cr | output | 32 | Condition register, field 0 in bits [31:28] |
| pc | output | 64 | Program counter |
| illegal | output | 1 | Valid word was not recognised |

## Verification
A decode fault appears in the same cycle as a wrong `gpr_we`, `gpr_waddr` or `illegal`, because these outputs are combinational from the word. A fault in the compare view or the nibble ordering appears in `cr[31:28]` one edge after the instruction. The vector table therefore holds results whose 64-bit and 32-bit signs differ. A faulty program-counter or condition-register hold shows as a changed `pc` or `cr` one edge after an illegal or idle cycle.

// File: rtl/xor_record_unit.sv
module xor_record_unit #(
  parameter int XLEN     = 64,
  parameter int RIDX_W   = 5,
  parameter int ILEN     = 32,
  parameter int CR_W     = 32,
  parameter int PRIMARY  = 31,
  parameter int EXTENDED = 316,
  parameter int PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [ILEN-1:0]   instr,
  input  logic              xer_so,
  input  logic              compat_mode,
  input  logic [XLEN-1:0]   rs_data,
  input  logic [XLEN-1:0]   rb_data,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rb_idx,
  output logic              gpr_we,
  output logic [RIDX_W-1:0] gpr_waddr,
  output logic [XLEN-1:0]   gpr_wdata,
  output logic [CR_W-1:0]   cr,
  output logic [XLEN-1:0]   pc,
  output logic              illegal
);
  localparam int OP_W   = 6;
  localparam int XO_W   = 10;
  localparam int OP_LO  = ILEN - OP_W;
  localparam int RS_LO  = OP_LO - RIDX_W;
  localparam int RA_LO  = RS_LO - RIDX_W;
  localparam int RB_LO  = RA_LO - RIDX_W;
  localparam int XO_LO  = 1;
  localparam int HALF   = 32;
  localparam int FLD_W  = 4;

  logic [OP_W-1:0]  op_f;
  logic [XO_W-1:0]  xo_f;
  logic             rc_f;
  logic             match, exec;
  logic [XLEN-1:0]  result, view;
  logic             lt, gt, eq;
  logic [FLD_W-1:0] cr0_next;
  logic [CR_W-1:0]  cr_q;
  logic [XLEN-1:0]  pc_q;

  assign op_f      = instr[ILEN-1 -: OP_W];
  assign xo_f      = instr[XO_LO +: XO_W];
  assign rc_f      = instr[0];
  assign rs_idx    = instr[RS_LO +: RIDX_W];
  assign gpr_waddr = instr[RA_LO +: RIDX_W];
  assign rb_idx    = instr[RB_LO +: RIDX_W];

  assign match   = (op_f == OP_W'(PRIMARY)) && (xo_f == XO_W'(EXTENDED));
  assign exec    = valid && match;
  assign illegal = valid && !match;
  assign gpr_we  = exec;

  assign result    = rs_data ^ rb_data;
  assign gpr_wdata = result;

  assign view = compat_mode ? {{(XLEN-HALF){result[HALF-1]}}, result[HALF-1:0]} : result;
  assign lt   = view[XLEN-1];
  assign eq   = (view == '0);
  assign gt   = !lt && !eq;
  assign cr0_next = {lt, gt, eq, xer_so};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      cr_q <= '0;
    end else if (exec) begin
      pc_q <= pc_q + XLEN'(PC_STEP);
      if (rc_f) cr_q[CR_W-1 -: FLD_W] <= cr0_next;
    end
  end

  assign cr = cr_q;
  assign pc = pc_q;

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (pc == '0 && cr == '0));

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    exec |=> pc == $past(pc) + XLEN'(PC_STEP));

  assert_illegal_holds_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> ($stable(pc) && $stable(cr)));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(pc) && $stable(cr)));

  assert_no_record_R6: assert property (@(posedge clk) disable iff (rst)
    (exec && !rc_f) |=> $stable(cr));

  assert_low_fields_R7: assert property (@(posedge clk) disable iff (rst)
    $stable(cr[CR_W-FLD_W-1:0]));

  assert_one_relation_R3: assert property (@(posedge clk) disable iff (rst)
    (exec && rc_f) |=> $countones(cr[CR_W-1 -: 3]) == 1);

  assert_so_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (exec && rc_f) |=> cr[CR_W-FLD_W] == $past(xer_so));

  assert_we_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(gpr_we && illegal));
endmodule

// File: tb/xor_record_unit_test.sv
module xor_record_unit_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        valid = 0;
  logic [31:0] instr = '0;
  logic        xer_so = 0;
  logic        compat_mode = 0;
  logic [63:0] rs_data = '0, rb_data = '0;
  logic [4:0]  rs_idx, rb_idx, gpr_waddr;
  logic        gpr_we, illegal;
  logic [63:0] gpr_wdata, pc;
  logic [31:0] cr;

  int checks = 0, failures = 0;
  logic [63:0] exp_pc = '0;

  always #5 clk = ~clk;

  xor_record_unit uut (
    .clk(clk), .rst(rst), .valid(valid), .instr(instr), .xer_so(xer_so),
    .compat_mode(compat_mode), .rs_data(rs_data), .rb_data(rb_data),
    .rs_idx(rs_idx), .rb_idx(rb_idx), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .cr(cr), .pc(pc), .illegal(illegal));

  // a, b, record flag, compat, so, expected {LT,GT,EQ,SO}
  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        rc;
    logic        cm;
    logic        so;
    logic [3:0]  nib;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{64'h5, 64'h3, 1'b1, 1'b0, 1'b0, 4'b0100},
    '{64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b0, 1'b1, 4'b1001},
    '{64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b1, 1'b1, 4'b0011},
    '{64'h0000_0000_8000_0000, 64'h0, 1'b1, 1'b1, 1'b0, 4'b1000},
    '{64'h0000_0000_8000_0000, 64'h0, 1'b1, 1'b0, 1'b0, 4'b0100},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 4'b0011},
    '{64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, 1'b1, 4'b0011},
    '{64'h0000_0001_0000_0000, 64'h0, 1'b1, 1'b1, 1'b0, 4'b0010},
    '{64'h0000_0001_0000_0000, 64'h0, 1'b1, 1'b0, 1'b0, 4'b0100}
  };

  function automatic logic [31:0] mk(input int op, input int rs, input int ra,
                                     input int rb, input int xo, input bit rc);
    return {op[5:0], rs[4:0], ra[4:0], rb[4:0], xo[9:0], rc};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] cr_before;
    logic [63:0] pc_before;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 0;
    chk("R11 pc after reset", pc, 0);
    chk("R11 cr after reset", {32'h0, cr}, 0);
    chk("R1 word constant", {32'h0, mk(31, 0, 0, 0, 316, 0)}, 64'h7C000278);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cr_before = cr;
      instr = mk(31, i + 1, 31 - i, i + 10, 316, VECS[i].rc);
      rs_data = VECS[i].a; rb_data = VECS[i].b;
      compat_mode = VECS[i].cm; xer_so = VECS[i].so; valid = 1;
      #1;
      chk("R1 write enable", {63'h0, gpr_we}, 1);
      chk("R1 write address", {59'h0, gpr_waddr}, 31 - i);
      chk("R1 source indices", {54'h0, rs_idx, rb_idx}, {54'h0, 5'(i + 1), 5'(i + 10)});
      chk("R2 R5 write data", gpr_wdata, VECS[i].a ^ VECS[i].b);
      @(negedge clk);
      valid = 0;
      exp_pc += 4;
      chk("R8 pc step", pc, exp_pc);
      if (VECS[i].rc)
        chk("R3 R4 R5 cr0 nibble", {60'h0, cr[31:28]}, {60'h0, VECS[i].nib});
      else
        chk("R6 cr untouched", {32'h0, cr}, {32'h0, cr_before});
      chk("R7 other fields", {36'h0, cr[27:0]}, 0);
    end

    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      instr = mk(31, 7, 3, 7, 316, 1);
      rs_data = 64'hDEAD_BEEF_0123_4567; rb_data = 64'hDEAD_BEEF_0123_4567;
      compat_mode = m[0]; xer_so = 0; valid = 1;
      #1;
      chk("R12 same source zero", gpr_wdata, 0);
      @(negedge clk);
      valid = 0; exp_pc += 4;
      chk("R12 eq set", {60'h0, cr[31:28]}, 64'b0010);
    end

    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cr_before = cr; pc_before = pc;
      instr = (k == 0) ? mk(31, 1, 2, 3, 317, 1) : mk(30, 1, 2, 3, 316, 1);
      rs_data = 64'h1; rb_data = 64'h0; xer_so = 1; valid = 1;
      #1;
      chk("R9 illegal flag", {63'h0, illegal}, 1);
      chk("R9 write blocked", {63'h0, gpr_we}, 0);
      @(negedge clk);
      valid = 0;
      chk("R9 pc held", pc, pc_before);
      chk("R9 cr held", {32'h0, cr}, {32'h0, cr_before});
    end

    @(negedge clk);
    cr_before = cr; pc_before = pc;
    instr = mk(31, 1, 2, 3, 316, 1); rs_data = 64'h8000_0000_0000_0000; xer_so = 1;
    valid = 0;
    #1;
    chk("R10 idle no write", {62'h0, gpr_we, illegal}, 0);
    @(negedge clk);
    chk("R10 idle pc", pc, pc_before);
    chk("R10 idle cr", {32'h0, cr}, {32'h0, cr_before});

    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R11 pc cleared again", pc, 0);
    chk("R11 cr cleared again", {32'h0, cr}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule